// File: doc/BRIEF.md
# Pulse-Width Bit Serializer

This block turns a stream of parallel data words into a single output line on which every bit is a fixed-length symbol. Each symbol begins high. The time the line stays high tells a receiver whether the bit is a zero or a one. At the default 48 MHz clock a symbol is 60 clocks long, which gives about 21 ns of timing resolution. A frame holds a fixed number of bits (360 by default). The symbols of a frame follow one another with no idle time between them.

A frame begins with a single-cycle `start` request. The block then pulls words through a valid/ready handshake. It keeps one word in reserve while the current word is shifted out most significant bit first, so the symbol stream does not pause between words. When the final symbol has finished, `done` pulses for one cycle. If the source fails to supply a word in time, the block abandons the frame: the line goes low, `underrun` is raised, and the block returns to rest without a `done` pulse.

The controller has four states:
- IDLE: at rest.
- PRIME: waiting for the first word.
- SEND: emitting symbols.
- FINISH: closing the last symbol.

The transitions are:
- *start request*: IDLE to PRIME.
- *first word ready*: PRIME to SEND.
- *bit advance*: SEND to SEND, at a symbol end when another bit is available.
- *last symbol*: SEND to FINISH.
- *underrun abort*: SEND to IDLE.
- *frame close*: FINISH to IDLE.

Top module: `pw_serializer`

## Requirements
- R1: After reset and while no frame is active, `tx_line`, `busy`, `done`, `underrun` and `in_ready` are all 0.
- R2: A 0 bit is sent as 17 clocks with `tx_line` high followed by 43 clocks low.
- R3: A 1 bit is sent as 43 clocks with `tx_line` high followed by 17 clocks low. No high run is ever longer than 43 clocks.
- R4: A frame carries exactly FRAME_BITS (360) symbols. Consecutive symbol starts are exactly 60 clocks apart, with no gaps.
- R5: Each word is sent starting from bit WORD_W-1 (the MSB) down to bit 0. Words go out in the order they were accepted.
- R6: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only while a frame is active, the reserve slot is empty, and the frame still needs words. Exactly ceil(FRAME_BITS/WORD_W) words (45) are accepted per frame, even when more are offered.
- R7: `start` is acted on only in IDLE, and a `start` during an active frame has no effect. After `start`, `tx_line` stays low until the first word has been accepted.
- R8: `busy` is 1 from the cycle after `start` until the frame ends. `done` is a single-cycle pulse in the cycle right after the last low clock of the final symbol, and `busy` is already 0 in that cycle.
- R9: If the reserve slot is empty when the current word runs out mid-frame, the frame is abandoned. `tx_line` stays low, `busy` drops, no `done` pulse is issued, and `underrun` is set. `underrun` stays set until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock (48 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to begin a frame |
| in_valid | input | 1 | Source has a word on `in_data` |
| in_ready | output | 1 | Block will take a word this cycle |
| in_data | input | WORD_W | Data word, sent MSB first |
| tx_line | output | 1 | Pulse-width encoded serial output, registered |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a complete frame |
| underrun | output | 1 | Sticky flag: the last frame was abandoned for lack of data |

## Verification
The bench decodes the line purely from edge timing and checks each bit against the words it supplied. This catches swapped high times, LSB-first ordering, and a missing or extra clock between symbols, which would show up as a symbol period other than 60. One scenario offers more words than a frame needs, to catch a design that over-fetches. Another pulses `start` in the middle of a frame, to catch a design that restarts or shortens the frame. A source that pauses between words, and one that delays its first word, test whether the reserve slot hides those delays or whether the line starts early. A source that stops after one word must leave the line low and the flag raised with no `done` pulse. The frame that follows must clear the flag and run normally. A design that is off by a cycle at the end of the frame is caught by measuring the distance from the last falling edge to `done`.

// File: rtl/pw_ser_pkg.sv
package pw_ser_pkg;

    // Controller states of the serializer
    typedef enum logic [1:0] {
        PW_IDLE   = 2'd0,
        PW_PRIME  = 2'd1,
        PW_SEND   = 2'd2,
        PW_FINISH = 2'd3
    } pw_state_e;

endpackage

// File: rtl/pw_sym_timer.sv
// Symbol phase counter: runs 0..SYM_CLKS-1 while enabled and reports
// the high/low level of the symbol for the current bit value.
module pw_sym_timer #(
    parameter int SYM_CLKS  = 60,
    parameter int HIGH_ZERO = 17,
    parameter int HIGH_ONE  = 43
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_val,
    output logic sym_end,
    output logic hi_level
);
    localparam int PH_W = (SYM_CLKS > 2) ? $clog2(SYM_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_CLKS - 1);
    localparam logic [PH_W-1:0] HI_ZERO = PH_W'(HIGH_ZERO);
    localparam logic [PH_W-1:0] HI_ONE  = PH_W'(HIGH_ONE);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] hi_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    always_comb begin
        hi_len   = bit_val ? HI_ONE : HI_ZERO;
        hi_level = run && (phase_q < hi_len);
        sym_end  = run && (phase_q == PH_LAST);
    end

endmodule

// File: rtl/pw_word_buf.sv
// Current word shift register plus one reserve slot filled by a
// valid/ready handshake, limited to the number of words a frame needs.
module pw_word_buf #(
    parameter int WORD_W = 8,
    parameter int WORDS  = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              fill_en,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              take,
    input  logic              shift,
    output logic              in_ready,
    output logic              nxt_full,
    output logic              cur_bit,
    output logic              cur_last
);
    localparam int WC_W = $clog2(WORDS + 1);
    localparam int BC_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] cur_q;
    logic [WORD_W-1:0] nxt_q;
    logic              nxt_full_q;
    logic [WC_W-1:0]   words_left_q;
    logic [BC_W-1:0]   cur_left_q;
    logic              accept;

    always_comb begin
        in_ready = fill_en && !nxt_full_q && (words_left_q != '0);
        accept   = in_valid && in_ready;
        nxt_full = nxt_full_q;
        cur_bit  = cur_q[WORD_W-1];
        cur_last = (cur_left_q == BC_W'(1));
    end

    // Reserve slot and word budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q        <= '0;
            nxt_full_q   <= 1'b0;
            words_left_q <= '0;
        end else if (arm) begin
            nxt_full_q   <= 1'b0;
            words_left_q <= WC_W'(WORDS);
        end else if (accept) begin
            nxt_q        <= in_data;
            nxt_full_q   <= 1'b1;
            words_left_q <= words_left_q - WC_W'(1);
        end else if (take) begin
            nxt_full_q   <= 1'b0;
        end
    end

    // Current word, shifted towards the MSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_left_q <= '0;
        end else if (arm) begin
            cur_left_q <= '0;
        end else if (take) begin
            cur_q      <= nxt_q;
            cur_left_q <= BC_W'(WORD_W);
        end else if (shift) begin
            cur_q      <= {cur_q[WORD_W-2:0], 1'b0};
            cur_left_q <= cur_left_q - BC_W'(1);
        end
    end

endmodule

// File: rtl/pw_seq_fsm.sv
// Frame controller: sequences bits, detects the last symbol and underrun,
// and registers the line, done and underrun outputs.
module pw_seq_fsm
    import pw_ser_pkg::*;
#(
    parameter int FRAME_BITS = 360
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic nxt_full,
    input  logic cur_last,
    input  logic sym_end,
    input  logic hi_level,
    output logic arm,
    output logic fill_en,
    output logic run,
    output logic take,
    output logic shift,
    output logic busy,
    output logic tx_line,
    output logic done,
    output logic underrun
);
    localparam int FB_W = $clog2(FRAME_BITS + 1);

    pw_state_e       state_q, state_d;
    logic [FB_W-1:0] frame_left_q;
    logic            frame_last;
    logic            advance;
    logic            starve;
    logic            tx_q, done_q, underrun_q;

    always_comb begin
        frame_last = (frame_left_q == FB_W'(1));
        arm        = (state_q == PW_IDLE) && start;
        run        = (state_q == PW_SEND);
        fill_en    = (state_q == PW_PRIME) || (state_q == PW_SEND);
        busy       = (state_q != PW_IDLE);
        advance    = run && sym_end && !frame_last;
        shift      = advance && !cur_last;
        take       = ((state_q == PW_PRIME) && nxt_full) ||
                     (advance && cur_last && nxt_full);
        starve     = advance && cur_last && !nxt_full;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE:   if (start)    state_d = PW_PRIME;
            PW_PRIME:  if (nxt_full) state_d = PW_SEND;
            PW_SEND: begin
                if (sym_end && frame_last) state_d = PW_FINISH;
                else if (starve)           state_d = PW_IDLE;
            end
            PW_FINISH: state_d = PW_IDLE;
            default:   state_d = PW_IDLE;
        endcase
    end

    // Frame bit budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_left_q <= '0;
        end else if (arm) begin
            frame_left_q <= FB_W'(FRAME_BITS);
        end else if (run && sym_end) begin
            frame_left_q <= frame_left_q - FB_W'(1);
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q       <= 1'b0;
            done_q     <= 1'b0;
            underrun_q <= 1'b0;
        end else begin
            tx_q   <= hi_level;
            done_q <= (state_q == PW_FINISH);
            if (arm) begin
                underrun_q <= 1'b0;
            end else if (starve) begin
                underrun_q <= 1'b1;
            end
        end
    end

    assign tx_line  = tx_q;
    assign done     = done_q;
    assign underrun = underrun_q;

endmodule

// File: rtl/pw_serializer.sv
// Pulse-width encoded bit serializer, top level.
module pw_serializer #(
    parameter int WORD_W     = 8,
    parameter int FRAME_BITS = 360,
    parameter int SYM_CLKS   = 60,
    parameter int HIGH_ZERO  = 17,
    parameter int HIGH_ONE   = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              tx_line,
    output logic              busy,
    output logic              done,
    output logic              underrun
);
    localparam int WORDS = (FRAME_BITS + WORD_W - 1) / WORD_W;

    logic arm, fill_en, run, take, shift;
    logic nxt_full, cur_bit, cur_last;
    logic sym_end, hi_level;

    pw_word_buf #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .fill_en  (fill_en),
        .in_valid (in_valid),
        .in_data  (in_data),
        .take     (take),
        .shift    (shift),
        .in_ready (in_ready),
        .nxt_full (nxt_full),
        .cur_bit  (cur_bit),
        .cur_last (cur_last)
    );

    pw_sym_timer #(
        .SYM_CLKS  (SYM_CLKS),
        .HIGH_ZERO (HIGH_ZERO),
        .HIGH_ONE  (HIGH_ONE)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .bit_val  (cur_bit),
        .sym_end  (sym_end),
        .hi_level (hi_level)
    );

    pw_seq_fsm #(
        .FRAME_BITS (FRAME_BITS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .nxt_full (nxt_full),
        .cur_last (cur_last),
        .sym_end  (sym_end),
        .hi_level (hi_level),
        .arm      (arm),
        .fill_en  (fill_en),
        .run      (run),
        .take     (take),
        .shift    (shift),
        .busy     (busy),
        .tx_line  (tx_line),
        .done     (done),
        .underrun (underrun)
    );

endmodule

// File: rtl/pw_serializer_chk.sv
// Port-level checker for pw_serializer.
module pw_serializer_chk #(
    parameter int SYM_CLKS = 60,
    parameter int HIGH_ONE = 43
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic tx_line,
    input logic busy,
    input logic done,
    input logic underrun
);
    localparam int RW = $clog2(SYM_CLKS + 2);
    localparam logic [RW-1:0] RUN_LIM = RW'(HIGH_ONE);
    localparam logic [RW-1:0] RUN_SAT = RW'(SYM_CLKS + 1);

    logic [RW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (!tx_line) begin
            hi_run <= '0;
        end else if (hi_run != RUN_SAT) begin
            hi_run <= hi_run + RW'(1);
        end
    end

    a_r1_line_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_line);

    a_r6_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    a_r3_high_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= RUN_LIM);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r9_underrun_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!busy && !tx_line));

    a_r9_no_done_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !done);

endmodule

bind pw_serializer pw_serializer_chk #(
    .SYM_CLKS (SYM_CLKS),
    .HIGH_ONE (HIGH_ONE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .tx_line  (tx_line),
    .busy     (busy),
    .done     (done),
    .underrun (underrun)
);

// File: tb/pw_serializer_tb.sv
`timescale 1ns/1ps
module pw_serializer_tb;
    localparam int CLK_PERIOD = 20;
    localparam int WORD_W     = 8;
    localparam int FRAME_BITS = 360;
    localparam int SYM_CLKS   = 60;
    localparam int HIGH_ZERO  = 17;
    localparam int HIGH_ONE   = 43;
    localparam int WORDS      = (FRAME_BITS + WORD_W - 1) / WORD_W;
    localparam int MAX_WORDS  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              in_valid = 1'b0;
    logic [WORD_W-1:0] in_data = '0;
    logic              in_ready, tx_line, busy, done, underrun;

    pw_serializer #(
        .WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS), .SYM_CLKS(SYM_CLKS),
        .HIGH_ZERO(HIGH_ZERO), .HIGH_ONE(HIGH_ONE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .tx_line(tx_line),
        .busy(busy), .done(done), .underrun(underrun)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- word source ----------------
    logic [WORD_W-1:0] words [MAX_WORDS];
    int n_offer = 0, feed_idx = 0, feed_gap = 0, gap_cnt = 0, accepted = 0;
    bit feed_en = 1'b0, fire = 1'b0;

    initial begin : feeder
        forever begin
            @(negedge clk);
            if (fire) begin
                feed_idx++;
                accepted++;
                gap_cnt = feed_gap;
            end
            if (gap_cnt > 0) begin
                gap_cnt--;
                in_valid = 1'b0;
            end else begin
                in_valid = feed_en && (feed_idx < n_offer);
            end
            in_data = (feed_idx < MAX_WORDS) ? words[feed_idx] : '0;
            fire = in_valid && in_ready;
        end
    end

    function automatic bit exp_bit(input int k);
        int w = k / WORD_W;
        if (w >= MAX_WORDS) return 1'b0;
        return words[w][WORD_W - 1 - (k % WORD_W)];
    endfunction

    // ---------------- line decoder ----------------
    bit mon_prev = 1'b0;
    int cyc = 0, rises = 0, nbits = 0, badw = 0, mism = 0, gaps = 0;
    int done_cnt = 0, last_rise = 0, last_fall = 0, last_width = 0, done_delay = -1;
    int zeros = 0, ones = 0;

    initial begin : decoder
        forever begin
            @(negedge clk);
            cyc++;
            if (tx_line && !mon_prev) begin
                if (rises > 0 && (cyc - last_rise) != SYM_CLKS) gaps++;
                last_rise = cyc;
                rises++;
            end
            if (!tx_line && mon_prev) begin
                int w;
                bit b;
                w = cyc - last_rise;
                last_width = w;
                last_fall = cyc;
                b = 1'b0;
                if (w == HIGH_ZERO) zeros++;
                else if (w == HIGH_ONE) begin ones++; b = 1'b1; end
                else badw++;
                if ((w == HIGH_ZERO || w == HIGH_ONE) && b != exp_bit(nbits)) mism++;
                nbits++;
            end
            if (done) begin
                done_cnt++;
                done_delay = cyc - last_fall;
            end
            mon_prev = tx_line;
        end
    end

    task automatic mon_clear();
        rises = 0; nbits = 0; badw = 0; mism = 0; gaps = 0;
        done_cnt = 0; done_delay = -1; zeros = 0; ones = 0;
    endtask

    task automatic fill_words(input int kind);
        for (int i = 0; i < MAX_WORDS; i++) begin
            case (kind)
                0:       words[i] = WORD_W'(8'hA5 ^ (i * 37));
                1:       words[i] = (i % 2 == 0) ? WORD_W'(8'hF0) : WORD_W'(8'h01);
                default: words[i] = WORD_W'(i * 29 + 3);
            endcase
        end
    endtask

    task automatic idle_source();
        feed_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        fire = 1'b0;
        feed_idx = 0;
        accepted = 0;
        gap_cnt = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic test_reset();
        repeat (4) @(negedge clk);
        check_eq("R1", "tx_line in reset", int'(tx_line), 0);
        check_eq("R1", "busy in reset", int'(busy), 0);
        #1 rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1", "tx_line idle", int'(tx_line), 0);
        check_eq("R1", "busy idle", int'(busy), 0);
        check_eq("R1", "done idle", int'(done), 0);
        check_eq("R1", "underrun idle", int'(underrun), 0);
        check_eq("R1", "in_ready idle", int'(in_ready), 0);
    endtask

    task automatic test_frame(input string tag, input int kind, input int first_delay,
                              input int gap, input bit mid_start);
        int exp_ones;
        int waited;
        $display("scenario %s", tag);
        idle_source();
        fill_words(kind);
        n_offer = WORDS + 5;
        feed_gap = gap;
        exp_ones = 0;
        for (int k = 0; k < FRAME_BITS; k++) exp_ones += int'(exp_bit(k));
        mon_clear();
        pulse_start();
        check_eq("R8", {tag, " busy after start"}, int'(busy), 1);
        check_eq("R9", {tag, " underrun cleared by start"}, int'(underrun), 0);
        if (first_delay > 0) begin
            repeat (first_delay) @(negedge clk);
            #1;
            check_eq("R7", {tag, " line low before first word"}, rises, 0);
            check_eq("R6", {tag, " ready while waiting"}, int'(in_ready), 1);
        end
        feed_en = 1'b1;
        if (mid_start) begin
            repeat (1000) @(negedge clk);
            pulse_start();
        end
        waited = 0;
        while (done_cnt == 0 && waited < FRAME_BITS * SYM_CLKS + 5000) begin
            @(negedge clk);
            waited++;
        end
        repeat (5) @(negedge clk);
        #1;
        check_eq("R4", {tag, " symbols per frame"}, nbits, FRAME_BITS);
        check_eq("R4", {tag, " symbol period errors"}, gaps, 0);
        check_eq("R2", {tag, " illegal high widths"}, badw, 0);
        check_eq("R2", {tag, " zero symbols"}, zeros, FRAME_BITS - exp_ones);
        check_eq("R3", {tag, " one symbols"}, ones, exp_ones);
        check_eq("R5", {tag, " bit order mismatches"}, mism, 0);
        check_eq("R6", {tag, " words accepted"}, accepted, WORDS);
        check_eq("R8", {tag, " done pulses"}, done_cnt, 1);
        check_eq("R8", {tag, " done delay after last fall"}, done_delay, SYM_CLKS - last_width);
        check_eq("R8", {tag, " busy after frame"}, int'(busy), 0);
        check_eq("R9", {tag, " no underrun"}, int'(underrun), 0);
        check_eq("R6", {tag, " ready after frame"}, int'(in_ready), 0);
        if (mid_start) check_eq("R7", {tag, " mid-frame start ignored"}, rises, FRAME_BITS);
    endtask

    task automatic test_underrun();
        int rises_then;
        $display("scenario underrun");
        idle_source();
        fill_words(2);
        n_offer = 1;
        feed_gap = 0;
        mon_clear();
        pulse_start();
        feed_en = 1'b1;
        repeat (700) @(negedge clk);
        #1;
        check_eq("R9", "symbols before abort", nbits, WORD_W);
        check_eq("R9", "bit errors before abort", mism + badw, 0);
        check_eq("R9", "underrun flag", int'(underrun), 1);
        check_eq("R9", "busy after abort", int'(busy), 0);
        check_eq("R9", "line after abort", int'(tx_line), 0);
        check_eq("R9", "no done on abort", done_cnt, 0);
        check_eq("R9", "ready after abort", int'(in_ready), 0);
        rises_then = rises;
        repeat (200) @(negedge clk);
        #1;
        check_eq("R9", "line stays low", rises, rises_then);
        check_eq("R9", "underrun sticky", int'(underrun), 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        test_reset();
        test_frame("mixed_midstart", 0, 0, 0, 1'b1);
        test_frame("slow_source", 1, 50, 150, 1'b0);
        test_underrun();
        test_frame("recovery", 2, 0, 0, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule